// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block is a windowed watchdog timer that advances on an instruction-cycle enable. Software keeps it alive by writing one byte to a service register. That byte carries three fields. The 2-bit upper-window select sits in bits 7:6. A 5-bit key sits in bits 5:1. A clock-monitor enable sits in bit 0. A service is accepted only when it lands between a fixed lower bound and a selectable upper bound, both counted from the last restart. Otherwise the block emits an error pulse.

The first accepted write after reset sets the window and the monitor option, and both are frozen from then on. While the core is halted or idle, the window checks pause. An external clock-fail flag is still turned into an error whenever the monitor option is on. The wake-up strobes restart the window.

Top module: `wdt_keyed_window`

## Requirements
- R1: After reset, `rd_data` reads 8'hC1: select 11, key field zero, monitor on. At all times `rd_data` returns the stored select in bits 7:6 and the stored monitor bit in bit 0, with bits 5:1 read as zero.
- R2: Before the first accepted service, a write whose bits 5:1 equal 5'b01100 is accepted at any count, even below the lower bound. It stores bits 7:6 and bit 0 and raises no error. A write with any other key raises an error and leaves the settings unchanged.
- R3: After the first service, a fully matching write made while the count is below LOWER_CYCLES (default 2048) raises an error. The same write made at a count of exactly LOWER_CYCLES is accepted.
- R4: After the first service, a write whose key, select or monitor bit differs from the stored or fixed value raises an error.
- R5: With no service, an error is raised on the BASE_UPPER<<select-th enabled cycle after the last restart, and the count then starts again. The defaults are 8192, 16384, 32768 and 65536 for select 00 to 11.
- R6: A valid service restarts the count with no error. This includes a service on the last enabled cycle of the window.
- R7: Once the first service is accepted, no later write changes the stored select or monitor bit.
- R8: `wd_error` is a registered pulse, high for the clock after the violating edge. Every violation, including an early or mismatched write, restarts the count from zero.
- R9: While `halt` or `idle` is high, the count holds, writes are ignored and no expiry occurs.
- R10: A rising edge of `clk_fail` raises an error when the stored monitor bit is 1, including during halt or idle. It has no effect when the bit is 0.
- R11: A pulse on `idle_exit` or `halt_exit` restarts the count, so the lower bound applies again to the next service.
- R12: The count advances only on clocks where `cycle_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_en | input | 1 | Instruction-cycle enable |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 8 | Service byte |
| rd_data | output | 8 | Service register readback |
| halt | input | 1 | Core halted |
| idle | input | 1 | Core idle |
| idle_exit | input | 1 | One-cycle strobe on leaving idle |
| halt_exit | input | 1 | One-cycle strobe on leaving halt |
| clk_fail | input | 1 | External clock-fail indication |
| wd_error | output | 1 | Watchdog error pulse |

## Verification
The bench targets the edges of the window. It writes one count below and exactly at the lower bound, and it services on the very cycle an expiry would fire. A design with an off-by-one bound would either flag the legal write or pass the early one. A design that let expiry win the tie would pulse after a good service.

It checks that the first write may come early while later ones may not. It also checks that a lock leak would show up as changed readback. The bench freezes the count across halt and then times the resulting expiry to the exact cycle. It also checks that the wake strobes re-arm the lower bound and that a stalled `cycle_en` delays expiry. A monitor that was level-sensitive, or one that ignored the stored bit, would produce extra or missing pulses.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int SEL_W = 2;
    localparam int KEY_W = 5;

    typedef struct packed {
        logic [SEL_W-1:0] win_sel;
        logic [KEY_W-1:0] key;
        logic             mon_en;
    } svc_byte_t;

    typedef struct packed {
        logic [SEL_W-1:0] win_sel;
        logic             mon_en;
        logic             locked;
    } wdt_cfg_t;

    typedef enum logic [1:0] {
        SVC_NONE      = 2'd0,
        SVC_GOOD      = 2'd1,
        SVC_FIELD_BAD = 2'd2,
        SVC_EARLY     = 2'd3
    } svc_verdict_e;

    localparam wdt_cfg_t CFG_RESET = '{win_sel: 2'b11, mon_en: 1'b1, locked: 1'b0};

    function automatic logic [7:0] cfg_readback(input wdt_cfg_t c);
        return {c.win_sel, {KEY_W{1'b0}}, c.mon_en};
    endfunction

    function automatic logic verdict_is_error(input svc_verdict_e v);
        return (v == SVC_FIELD_BAD) || (v == SVC_EARLY);
    endfunction

endpackage

// File: rtl/wdt_svc_check.sv
module wdt_svc_check
    import wdt_pkg::*;
#(
    parameter int                     CNT_W        = 16,
    parameter int                     LOWER_CYCLES = 2048,
    parameter logic [KEY_W-1:0]       SVC_KEY      = 5'b01100
) (
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             active,
    input  wdt_cfg_t         cfg,
    input  logic [CNT_W-1:0] cnt,
    output svc_verdict_e     verdict
);

    svc_byte_t fld;
    logic      key_ok;
    logic      fields_ok;
    logic      too_early;

    assign fld       = svc_byte_t'(wr_data);
    assign key_ok    = (fld.key == SVC_KEY);
    assign fields_ok = key_ok && (fld.win_sel == cfg.win_sel) && (fld.mon_en == cfg.mon_en);
    assign too_early = (cnt < CNT_W'(LOWER_CYCLES));

    always_comb begin
        verdict = SVC_NONE;
        if (wr_en && active) begin
            if (!cfg.locked) begin
                verdict = key_ok ? SVC_GOOD : SVC_FIELD_BAD;
            end else if (!fields_ok) begin
                verdict = SVC_FIELD_BAD;
            end else if (too_early) begin
                verdict = SVC_EARLY;
            end else begin
                verdict = SVC_GOOD;
            end
        end
    end

endmodule

// File: rtl/wdt_window_cnt.sv
module wdt_window_cnt
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int BASE_UPPER = 8192
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cycle_en,
    input  logic             active,
    input  logic             clear,
    input  logic [SEL_W-1:0] win_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    localparam int NUM_WIN = 1 << SEL_W;

    logic [CNT_W-1:0] lim_tab [NUM_WIN];
    logic [CNT_W-1:0] limit_m1;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'((BASE_UPPER << g) - 1);
    end

    assign limit_m1 = lim_tab[win_sel];
    assign expire   = active && cycle_en && !clear && (cnt == limit_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clear || expire) begin
            cnt <= '0;
        end else if (active && cycle_en) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r11_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (!active && !clear) |=> $stable(cnt));

    a_r12_no_enable: assert property (@(posedge clk) disable iff (rst)
        (!cycle_en && !clear) |=> $stable(cnt));

    a_r5_in_window: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit_m1);

endmodule

// File: rtl/wdt_clk_mon.sv
module wdt_clk_mon (
    input  logic clk,
    input  logic rst,
    input  logic clk_fail,
    input  logic mon_en,
    output logic fail_evt
);

    logic fail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
        end else begin
            fail_q <= clk_fail;
        end
    end

    assign fail_evt = mon_en && clk_fail && !fail_q;

endmodule

// File: rtl/wdt_keyed_window.sv
module wdt_keyed_window
    import wdt_pkg::*;
#(
    parameter int               LOWER_CYCLES = 2048,
    parameter int               BASE_UPPER   = 8192,
    parameter logic [KEY_W-1:0] SVC_KEY      = 5'b01100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cycle_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       halt,
    input  logic       idle,
    input  logic       idle_exit,
    input  logic       halt_exit,
    input  logic       clk_fail,
    output logic       wd_error
);

    localparam int NUM_WIN = 1 << SEL_W;
    localparam int CNT_W   = $clog2(BASE_UPPER) + NUM_WIN - 1;

    wdt_cfg_t         cfg;
    svc_byte_t        fld;
    svc_verdict_e     verdict;
    logic [CNT_W-1:0] cnt;
    logic             active;
    logic             clear;
    logic             expire;
    logic             mon_evt;
    logic             err_q;

    assign active  = !halt && !idle;
    assign fld     = svc_byte_t'(wr_data);
    assign clear   = (verdict != SVC_NONE) || idle_exit || halt_exit;
    assign rd_data = cfg_readback(cfg);

    wdt_svc_check #(
        .CNT_W       (CNT_W),
        .LOWER_CYCLES(LOWER_CYCLES),
        .SVC_KEY     (SVC_KEY)
    ) u_check (
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .active (active),
        .cfg    (cfg),
        .cnt    (cnt),
        .verdict(verdict)
    );

    wdt_window_cnt #(
        .CNT_W     (CNT_W),
        .BASE_UPPER(BASE_UPPER)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cycle_en(cycle_en),
        .active  (active),
        .clear   (clear),
        .win_sel (cfg.win_sel),
        .cnt     (cnt),
        .expire  (expire)
    );

    wdt_clk_mon u_mon (
        .clk     (clk),
        .rst     (rst),
        .clk_fail(clk_fail),
        .mon_en  (cfg.mon_en),
        .fail_evt(mon_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if ((verdict == SVC_GOOD) && !cfg.locked) begin
            cfg <= '{win_sel: fld.win_sel, mon_en: fld.mon_en, locked: 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= verdict_is_error(verdict) || expire || mon_evt;
        end
    end

    assign wd_error = err_q;

    a_r7_locked_hold: assert property (@(posedge clk) disable iff (rst)
        cfg.locked |=> $stable(cfg));

    a_r2_first_lock: assert property (@(posedge clk) disable iff (rst)
        ((verdict == SVC_GOOD) && !cfg.locked) |=> cfg.locked);

    a_r3_early_err: assert property (@(posedge clk) disable iff (rst)
        (verdict == SVC_EARLY) |=> wd_error);

    a_r4_field_err: assert property (@(posedge clk) disable iff (rst)
        (verdict == SVC_FIELD_BAD) |=> wd_error);

    a_r10_mon_err: assert property (@(posedge clk) disable iff (rst)
        mon_evt |=> wd_error);

    a_r6_good_quiet: assert property (@(posedge clk) disable iff (rst)
        ((verdict == SVC_GOOD) && !mon_evt) |=> !wd_error);

endmodule

// File: tb/wdt_keyed_window_tb.sv
`timescale 1ns/1ps
module wdt_keyed_window_tb;

    localparam int LOWER = 16;
    localparam int BASE  = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cycle_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       halt = 1'b0;
    logic       idle = 1'b0;
    logic       idle_exit = 1'b0;
    logic       halt_exit = 1'b0;
    logic       clk_fail = 1'b0;
    logic       wd_error;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int base = 0;
    bit done = 1'b0;

    int    exp_cyc [$];
    string exp_tag [$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    wdt_keyed_window #(
        .LOWER_CYCLES(LOWER),
        .BASE_UPPER  (BASE)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .cycle_en (cycle_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .halt     (halt),
        .idle     (idle),
        .idle_exit(idle_exit),
        .halt_exit(halt_exit),
        .clk_fail (clk_fail),
        .wd_error (wd_error)
    );

    // monitor: every error pulse must match the head of the expectation queue
    always begin
        @(posedge clk);
        #2;
        if (!rst && wd_error) begin
            checks++;
            if (exp_cyc.size() == 0) begin
                failures++;
                $display("FAIL R8 unexpected error pulse at cycle %0d: actual=1 expected=0", cyc);
            end else begin
                int    c;
                string t;
                c = exp_cyc.pop_front();
                t = exp_tag.pop_front();
                if (c != cyc) begin
                    failures++;
                    $display("FAIL %s error pulse cycle actual=%0d expected=%0d", t, cyc, c);
                end
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_to(int k);
        while (cyc - base < k) @(negedge clk);
    endtask

    task automatic push_err(int at, string tag);
        exp_cyc.push_back(at);
        exp_tag.push_back(tag);
    endtask

    task automatic write_svc(logic [7:0] b, bit bad, string tag);
        if (bad) push_err(cyc + 1, tag);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
        base    = cyc;
    endtask

    task automatic check_val(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic drain(string req);
        step(2);
        checks++;
        if (exp_cyc.size() != 0) begin
            failures++;
            $display("FAIL %s missing error pulses actual=%0d expected=0 pending, next due cycle %0d",
                     req, exp_cyc.size(), exp_cyc[0]);
            exp_cyc.delete();
            exp_tag.delete();
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        base = cyc;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        step(1);
        do_reset();
        // R1 reset state, R8 no error after reset
        check_val("R1 reset readback", rd_data, 8'hC1);
        check_val("R8 idle error output", wd_error, 0);

        // R2 wrong key on first service
        wait_to(3);
        write_svc(8'h00, 1'b1, "R2 first key mismatch");
        check_val("R2 settings kept after bad key", rd_data, 8'hC1);
        drain("R2");

        // R2 first good service may be early; select 01, monitor 0
        wait_to(2);
        write_svc(8'h58, 1'b0, "R2 first early ok");
        check_val("R1 key reads zero / R2 stored", rd_data, 8'h40);

        // R3 early service after lock
        wait_to(5);
        write_svc(8'h58, 1'b1, "R3 early");
        // R6 in-window valid service
        wait_to(20);
        write_svc(8'h58, 1'b0, "R6 valid");
        drain("R3 R6");

        // R4 mismatches, R7 lock
        wait_to(20);
        write_svc(8'h98, 1'b1, "R4 select mismatch");
        check_val("R7 select locked", rd_data, 8'h40);
        wait_to(20);
        write_svc(8'h59, 1'b1, "R4 monitor mismatch");
        check_val("R7 monitor locked", rd_data, 8'h40);
        wait_to(20);
        write_svc(8'h50, 1'b1, "R4 key mismatch");
        wait_to(20);
        write_svc(8'h58, 1'b0, "R6 valid after errors");
        drain("R4");

        // R5 expiry, select 01 -> 128 cycles, repeating
        push_err(base + 128, "R5 expiry first");
        push_err(base + 256, "R5 expiry second");
        base = base + 256;
        wait_to(2);
        drain("R5");
        check_val("R8 settings kept after expiry", rd_data, 8'h40);

        // R3 lower boundary, R6 upper boundary tie
        wait_to(LOWER - 1);
        write_svc(8'h58, 1'b1, "R3 one below bound");
        wait_to(LOWER);
        write_svc(8'h58, 1'b0, "R3 at bound");
        wait_to(127);
        write_svc(8'h58, 1'b0, "R6 last cycle of window");
        drain("R3 R6 boundaries");

        // R9 halt freezes count and ignores writes
        wait_to(100);
        halt = 1'b1;
        step(50);
        wr_en = 1'b1; wr_data = 8'h00;
        step(1);
        wr_en = 1'b0;
        step(250);
        halt = 1'b0;
        push_err(cyc + 28, "R9 expiry resumes after halt");
        base = cyc + 28;
        wait_to(2);
        drain("R9");
        check_val("R9 write ignored in halt", rd_data, 8'h40);

        // R10 monitor disabled: no pulse
        clk_fail = 1'b1;
        step(3);
        clk_fail = 1'b0;
        step(1);
        drain("R10 monitor off");

        // new reset: select 00, monitor on
        do_reset();
        check_val("R1 reset readback again", rd_data, 8'hC1);
        wait_to(1);
        write_svc(8'h19, 1'b0, "R2 first service monitor on");
        check_val("R2 stored select 00 monitor 1", rd_data, 8'h01);

        // R10 in idle with monitor on, R11 idle exit re-arms lower bound
        wait_to(40);
        idle = 1'b1;
        step(5);
        clk_fail = 1'b1;
        push_err(cyc + 1, "R10 clock fail in idle");
        step(5);
        clk_fail = 1'b0;
        step(2);
        idle = 1'b0;
        idle_exit = 1'b1;
        step(1);
        idle_exit = 1'b0;
        base = cyc;
        wait_to(5);
        write_svc(8'h19, 1'b1, "R11 early after idle exit");
        drain("R10 R11 idle");

        // R11 halt exit
        wait_to(40);
        halt = 1'b1;
        step(10);
        halt = 1'b0;
        halt_exit = 1'b1;
        step(1);
        halt_exit = 1'b0;
        base = cyc;
        wait_to(5);
        write_svc(8'h19, 1'b1, "R11 early after halt exit");
        drain("R11 halt");

        // R12 stalled cycle_en delays expiry (window 64)
        cycle_en = 1'b0;
        step(200);
        cycle_en = 1'b1;
        push_err(base + 264, "R12 expiry after stall");
        base = base + 264;
        wait_to(2);
        drain("R12");

        finish_run();
    end

endmodule